// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block forms the byte returned to a reader of a nonvolatile array while an internal programming cycle may still be running. When the program timer reports busy, a read does not return stored data. It returns two progress indicators instead. The most significant status bit is the inverse of the same bit of the byte most recently written. A second status bit changes value on every read made during the cycle. When the timer is idle, each read returns the array contents unchanged.

A host polls by issuing reads. Each new assertion of output enable, chip enable or both is presented to the block as a single-cycle read strobe. The host can stop polling once the inverted bit matches what it wrote, or once the alternating bit holds still between two reads. Polling may begin at any point in the programming cycle. The result is captured into an output register on the clock edge where the strobe is high, and it holds there until the next strobe.

Top module: `wr_status_rd`

## Requirements
- R1: After reset, `rd_data` is all zeros.
- R2: When a strobe is sampled with `busy` high, `rd_data[7]` one clock later equals the inverse of `last_wr[7]`.
- R3: Across successive strobes sampled with `busy` high, `rd_data[6]` takes opposite values. The first value after reset is not specified.
- R4: When a strobe is sampled with `busy` high, `rd_data[5:0]` one clock later equals `last_wr[5:0]`.
- R5: When a strobe is sampled with `busy` low, `rd_data` one clock later equals `arr_data` on all 8 bits.
- R6: A strobe sampled with `busy` low does not advance the alternating bit. The next busy read returns bit 6 opposite to the busy read made before the idle reads.
- R7: Without a strobe, `rd_data` keeps its value whatever `busy`, `last_wr` and `arr_data` do.
- R8: `busy` is judged only in the strobe cycle. A strobe in the first cycle that `busy` is high returns status. A strobe in the first cycle after `busy` falls returns true array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle pulse per host read |
| busy | input | 1 | Program timer running |
| last_wr | input | 8 | Byte most recently written |
| arr_data | input | 8 | True data read from the array |
| rd_data | output | 8 | Registered read value |

## Verification
A read strobe can land in the same cycle that the program timer drops `busy`. A read strobe can also land in the same cycle that `busy` first rises. The bench places the strobe exactly on the cycle where `busy` changes. It expects status or true data according to the value of `busy` at that edge alone. It then issues one more busy read to confirm that the alternating bit advanced only for the reads sampled as busy.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;

   // Source for the status bits that carry no progress information
   typedef enum logic {
      FILL_LAST  = 1'b0,
      FILL_ARRAY = 1'b1
   } fill_e;

   // Mask with ones on every bit except the two indicator positions
   function automatic logic [31:0] other_mask(input int width, input int pbit, input int tbit);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < width; i++) begin
         if (i != pbit && i != tbit) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/wr_status_tog.sv
module wr_status_tog #(
   parameter logic TOG_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic tog
);
   always_ff @(posedge clk) begin
      if (!rst_n)   tog <= TOG_INIT;
      else if (adv) tog <= ~tog;
   end
endmodule

// File: rtl/wr_status_compose.sv
module wr_status_compose
   import wr_status_pkg::*;
#(
   parameter int    DATA_W   = 8,
   parameter int    POLL_BIT = 7,
   parameter int    TOG_BIT  = 6,
   parameter fill_e FILL     = FILL_LAST
) (
   input  logic              busy,
   input  logic              tog,
   input  logic [DATA_W-1:0] last_wr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] value
);
   logic [DATA_W-1:0] stat;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign stat[i] = ~last_wr[i];
      end else if (i == TOG_BIT) begin : g_tog
         assign stat[i] = tog;
      end else if (FILL == FILL_LAST) begin : g_fill_last
         assign stat[i] = last_wr[i];
      end else begin : g_fill_arr
         assign stat[i] = arr_data[i];
      end
   end

   assign value = busy ? stat : arr_data;
endmodule

// File: rtl/wr_status_oreg.sv
module wr_status_oreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/wr_status_rd.sv
module wr_status_rd
   import wr_status_pkg::*;
#(
   parameter int    DATA_W   = 8,
   parameter int    POLL_BIT = 7,
   parameter int    TOG_BIT  = 6,
   parameter logic  TOG_INIT = 1'b0,
   parameter fill_e FILL     = FILL_LAST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              busy,
   input  logic [DATA_W-1:0] last_wr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int MIN_W = 2;

   if (DATA_W < MIN_W) begin : g_bad_w
      $error("wr_status_rd: DATA_W too small");
   end
   if (POLL_BIT >= DATA_W || TOG_BIT >= DATA_W || POLL_BIT < 0 || TOG_BIT < 0) begin : g_bad_pos
      $error("wr_status_rd: indicator bit outside data width");
   end
   if (POLL_BIT == TOG_BIT) begin : g_bad_same
      $error("wr_status_rd: indicator bits must differ");
   end

   logic              tog;
   logic              adv;
   logic [DATA_W-1:0] nxt;

   assign adv = rd_stb & busy;

   wr_status_tog #(.TOG_INIT(TOG_INIT)) u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .tog   (tog)
   );

   wr_status_compose #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .TOG_BIT  (TOG_BIT),
      .FILL     (FILL)
   ) u_comp (
      .busy     (busy),
      .tog      (tog),
      .last_wr  (last_wr),
      .arr_data (arr_data),
      .value    (nxt)
   );

   wr_status_oreg #(.DATA_W(DATA_W)) u_oreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_stb),
      .d     (nxt),
      .q     (rd_data)
   );
endmodule

// File: rtl/wr_status_rd_chk.sv
module wr_status_rd_chk
   import wr_status_pkg::*;
#(
   parameter int    DATA_W   = 8,
   parameter int    POLL_BIT = 7,
   parameter int    TOG_BIT  = 6,
   parameter fill_e FILL     = FILL_LAST
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_stb,
   input logic              busy,
   input logic [DATA_W-1:0] last_wr,
   input logic [DATA_W-1:0] arr_data,
   input logic [DATA_W-1:0] rd_data
);
   localparam logic [31:0]       MASK32 = other_mask(DATA_W, POLL_BIT, TOG_BIT);
   localparam logic [DATA_W-1:0] OMASK  = MASK32[DATA_W-1:0];

   logic pend;
   logic have_prev;
   logic prev_tog;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         have_prev <= 1'b0;
         prev_tog  <= 1'b0;
      end else begin
         pend <= rd_stb & busy;
         if (pend) begin
            have_prev <= 1'b1;
            prev_tog  <= rd_data[TOG_BIT];
         end
      end
   end

   // R2
   poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && busy) |=> (rd_data[POLL_BIT] == ~$past(last_wr[POLL_BIT])));

   // R3
   tog_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && have_prev) |-> (rd_data[TOG_BIT] != prev_tog));

   if (FILL == FILL_LAST) begin : g_fill_chk
      // R4
      fill_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_stb && busy) |=> ((rd_data & OMASK) == ($past(last_wr) & OMASK)));
   end

   // R5
   idle_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !busy) |=> (rd_data == $past(arr_data)));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));
endmodule

bind wr_status_rd wr_status_rd_chk #(
   .DATA_W   (DATA_W),
   .POLL_BIT (POLL_BIT),
   .TOG_BIT  (TOG_BIT),
   .FILL     (FILL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_stb   (rd_stb),
   .busy     (busy),
   .last_wr  (last_wr),
   .arr_data (arr_data),
   .rd_data  (rd_data)
);

// File: tb/sim_wr_status_rd.sv
`timescale 1ns/1ps
module sim_wr_status_rd;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_stb = 1'b0;
   logic       busy = 1'b0;
   logic [7:0] last_wr = '0;
   logic [7:0] arr_data = '0;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_err = 0;
   logic last_tog;
   bit   tog_known = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   wr_status_rd u0 (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy),
      .last_wr(last_wr), .arr_data(arr_data), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // one read: inputs applied at negedge, captured at next posedge, sampled at following negedge
   task automatic do_read(input logic b, input logic [7:0] lw, input logic [7:0] ad);
      busy = b; last_wr = lw; arr_data = ad; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   // busy read with full expectation of bits 7, 6 and the rest
   task automatic busy_read(input string req, input logic [7:0] lw, input logic [7:0] ad);
      logic [7:0] exp;
      do_read(1'b1, lw, ad);
      exp = {~lw[7], 1'bx, lw[5:0]};
      if (tog_known) exp[6] = ~last_tog;
      else           exp[6] = rd_data[6];
      check({req, " R2 bit7"}, {7'b0, rd_data[7]}, {7'b0, exp[7]});
      check({req, " R4 low bits"}, {2'b0, rd_data[5:0]}, {2'b0, exp[5:0]});
      if (tog_known) check({req, " R3 bit6"}, {7'b0, rd_data[6]}, {7'b0, exp[6]});
      last_tog  = rd_data[6];
      tog_known = 1'b1;
   endtask

   task automatic t_reset();
      check("R1 reset value", rd_data, 8'h00);
   endtask

   task automatic t_poll();
      busy_read("poll a", 8'h80, 8'h11);
      busy_read("poll b", 8'h3C, 8'hFF);
      busy_read("poll c", 8'hFF, 8'h00);
      busy_read("poll d", 8'h55, 8'hAA);
   endtask

   task automatic t_idle();
      do_read(1'b0, 8'h12, 8'hA5); check("R5 idle a", rd_data, 8'hA5);
      do_read(1'b0, 8'hFF, 8'h40); check("R5 idle b", rd_data, 8'h40);
      do_read(1'b0, 8'h00, 8'hC3); check("R5 idle c", rd_data, 8'hC3);
   endtask

   task automatic t_interleave();
      busy_read("R6 before idle", 8'h01, 8'h00);
      do_read(1'b0, 8'h01, 8'h7E); check("R6 idle between", rd_data, 8'h7E);
      do_read(1'b0, 8'h01, 8'h81); check("R6 idle between 2", rd_data, 8'h81);
      busy_read("R6 after idle", 8'h01, 8'h00);
   endtask

   task automatic t_hold();
      logic [7:0] held;
      do_read(1'b0, 8'h00, 8'h5A);
      held = rd_data;
      busy = 1'b1; last_wr = 8'hF0; arr_data = 8'h0F;
      repeat (3) @(negedge clk);
      check("R7 hold while busy", rd_data, held);
      busy = 1'b0; arr_data = 8'h99;
      repeat (2) @(negedge clk);
      check("R7 hold while idle", rd_data, held);
   endtask

   task automatic t_edge();
      // busy high for several cycles, strobe exactly when it drops
      busy = 1'b1; repeat (2) @(negedge clk);
      do_read(1'b0, 8'h80, 8'h6D);
      check("R8 strobe on busy fall", rd_data, 8'h6D);
      // strobe in the very first busy cycle
      busy_read("R8 strobe on busy rise", 8'h80, 8'h6D);
      busy = 1'b0;
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_poll();
      t_idle();
      t_interleave();
      t_hold();
      t_edge();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule